// File: doc/BRIEF.md
# Hub Semaphore Lock Manager

This block holds a small pool of lock bits that several processing cores share for mutual exclusion over multi-word data. It is reached through one hub port that an upstream arbiter has already granted. Only one request is applied in any cycle, so the locks never see two writers at once. Each lock has two bits of state: an inventory bit that records whether a core has taken the lock, and a state bit that the owner sets and clears to guard its data.

A request carries a valid strobe, a two-bit operation code and a lock identifier. Four operations are supported: take a lock from the pool, give a lock back, set a lock and clear a lock. The response is registered and appears on the cycle after the request. It carries a done strobe, the identifier acted on, the state the lock had before the request, and a failure flag for a take that found the pool empty.

Set and clear return the prior state, so a core that sets a lock and reads back 0 has acquired it. The inventory is advisory: set and clear act on any lock, allocated or not.

Top module: `hub_lock_mgr`

## Requirements
- R1: After reset every lock is free and every state bit is 0, and rsp_done is 0.
- R2: rsp_done is 1 in exactly the cycle after a cycle with req_valid = 1, and 0 in every other cycle.
- R3: Operation code 2'b00 (take) hands out the lowest-numbered free lock on rsp_id, with rsp_fail = 0 and rsp_prev = 0, and marks that lock in use.
- R4: A take clears the state bit of the lock it hands out, so a following set on that lock reports rsp_prev = 0.
- R5: A take when no lock is free reports rsp_fail = 1, rsp_id = 0 and rsp_prev = 0, and it changes no inventory or state bit.
- R6: Operation code 2'b10 (set) reports the lock's prior state on rsp_prev and leaves the state bit at 1.
- R7: Operation code 2'b11 (clear) reports the lock's prior state on rsp_prev and leaves the state bit at 0.
- R8: Operation code 2'b01 (give back) marks the lock free and reports its state on rsp_prev. The state bit keeps its value, and the lock can be taken again.
- R9: Set and clear on a free lock update its state bit and do not mark it in use.
- R10: For give back, set and clear, rsp_id equals the request's req_id and rsp_fail is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A request is present this cycle |
| req_op | input | 2 | Operation code: 00 take, 01 give back, 10 set, 11 clear |
| req_id | input | 3 | Target lock for give back, set and clear |
| rsp_done | output | 1 | Response valid, one cycle after the request |
| rsp_id | output | 3 | Lock acted on, or the lock handed out by a take |
| rsp_prev | output | 1 | State of the lock before the request |
| rsp_fail | output | 1 | A take found no free lock |

## Verification
The hardest case to reach is a take on an empty pool that arrives while state bits are mixed. The check must show that nothing moved, and that needs a full pool whose later set, clear and give-back responses expose the untouched bits. The stimulus first takes all eight locks and requests one more. It then probes the state bits through set and clear, frees two locks out of order to show that the lowest free one wins, and ends with a long random mix in which the pool fills and drains many times. A behavioural model in the bench is compared with the response on every clock.

// File: rtl/hsl_pkg.sv
package hsl_pkg;
  typedef enum logic [1:0] {
    OP_TAKE  = 2'b00,
    OP_GIVE  = 2'b01,
    OP_SET   = 2'b10,
    OP_CLEAR = 2'b11
  } lock_op_e;
endpackage

// File: rtl/hsl_free_finder.sv
module hsl_free_finder #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  used,
  output logic          any_free,
  output logic [IW-1:0] grant_id,
  output logic [N-1:0]  grant_oh
);
  logic [N-1:0] free_vec;

  function automatic logic [IW-1:0] lowest_index(input logic [N-1:0] v);
    logic [IW-1:0] idx;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (v[i]) idx = IW'(i);
    end
    return idx;
  endfunction

  assign free_vec = ~used;
  assign any_free = |free_vec;
  assign grant_id = lowest_index(free_vec);

  generate
    for (genvar g = 0; g < N; g++) begin : g_oh
      if (g == 0) begin : g_first
        assign grant_oh[g] = free_vec[g];
      end else begin : g_rest
        assign grant_oh[g] = free_vec[g] & ~(|free_vec[g-1:0]);
      end
    end
  endgenerate

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_oh)); // R3
  AST_GRANT_AGREES: assert property (@(posedge clk) disable iff (!rst_n)
    any_free |-> (grant_oh[grant_id] && !used[grant_id])); // R3
endmodule

// File: rtl/hsl_lock_bank.sv
module hsl_lock_bank #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take_fire,
  input  logic [IW-1:0] take_id,
  input  logic          give_fire,
  input  logic          set_fire,
  input  logic          clr_fire,
  input  logic [IW-1:0] tgt_id,
  input  logic          take_fail,
  output logic [N-1:0]  used_q,
  output logic [N-1:0]  state_q
);
  generate
    for (genvar g = 0; g < N; g++) begin : g_lock
      logic u_r, s_r;
      logic take_hit, give_hit, set_hit, clr_hit;
      assign take_hit = take_fire && (take_id == IW'(g));
      assign give_hit = give_fire && (tgt_id == IW'(g));
      assign set_hit  = set_fire  && (tgt_id == IW'(g));
      assign clr_hit  = clr_fire  && (tgt_id == IW'(g));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          u_r <= 1'b0;
          s_r <= 1'b0;
        end else begin
          if (take_hit)      u_r <= 1'b1;
          else if (give_hit) u_r <= 1'b0;
          if (take_hit || clr_hit) s_r <= 1'b0;
          else if (set_hit)        s_r <= 1'b1;
        end
      end
      assign used_q[g]  = u_r;
      assign state_q[g] = s_r;
    end
  endgenerate

  AST_TAKE_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
    take_fire |=> (used_q[$past(take_id)] && !state_q[$past(take_id)])); // R4
  AST_FAIL_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    take_fail |=> ($stable(used_q) && $stable(state_q))); // R5
  AST_SET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    set_fire |=> state_q[$past(tgt_id)]); // R6
  AST_CLEAR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_fire |=> !state_q[$past(tgt_id)]); // R7
  AST_GIVE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    give_fire |=> (!used_q[$past(tgt_id)] && $stable(state_q))); // R8
  AST_SETCLR_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (set_fire || clr_fire) |=> $stable(used_q)); // R9
endmodule

// File: rtl/hsl_resp.sv
module hsl_resp #(
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic [IW-1:0] id_d,
  input  logic          prev_d,
  input  logic          fail_d,
  output logic          done_q,
  output logic [IW-1:0] id_q,
  output logic          prev_q,
  output logic          fail_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      id_q   <= '0;
      prev_q <= 1'b0;
      fail_q <= 1'b0;
    end else begin
      done_q <= fire;
      id_q   <= fire ? id_d   : '0;
      prev_q <= fire ? prev_d : 1'b0;
      fail_q <= fire ? fail_d : 1'b0;
    end
  end
endmodule

// File: rtl/hub_lock_mgr.sv
module hub_lock_mgr #(
  parameter int NUM_LOCKS = 8,
  parameter int ID_W      = $clog2(NUM_LOCKS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [1:0]      req_op,
  input  logic [ID_W-1:0] req_id,
  output logic            rsp_done,
  output logic [ID_W-1:0] rsp_id,
  output logic            rsp_prev,
  output logic            rsp_fail
);
  import hsl_pkg::*;

  lock_op_e              op;
  logic [NUM_LOCKS-1:0]  used_q, state_q, grant_oh;
  logic                  any_free;
  logic [ID_W-1:0]       grant_id;
  logic                  is_take, take_fire, take_fail;
  logic                  give_fire, set_fire, clr_fire;
  logic [ID_W-1:0]       rsp_id_d;
  logic                  rsp_prev_d;

  assign op        = lock_op_e'(req_op);
  assign is_take   = req_valid && (op == OP_TAKE);
  assign take_fire = is_take && any_free;
  assign take_fail = is_take && !any_free;
  assign give_fire = req_valid && (op == OP_GIVE);
  assign set_fire  = req_valid && (op == OP_SET);
  assign clr_fire  = req_valid && (op == OP_CLEAR);

  hsl_free_finder #(.N(NUM_LOCKS), .IW(ID_W)) u_finder (
    .clk(clk), .rst_n(rst_n), .used(used_q),
    .any_free(any_free), .grant_id(grant_id), .grant_oh(grant_oh)
  );

  hsl_lock_bank #(.N(NUM_LOCKS), .IW(ID_W)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .take_fire(take_fire), .take_id(grant_id),
    .give_fire(give_fire), .set_fire(set_fire), .clr_fire(clr_fire),
    .tgt_id(req_id), .take_fail(take_fail),
    .used_q(used_q), .state_q(state_q)
  );

  always_comb begin
    if (is_take) begin
      rsp_id_d   = any_free ? grant_id : '0;
      rsp_prev_d = 1'b0;
    end else begin
      rsp_id_d   = req_id;
      rsp_prev_d = state_q[req_id];
    end
  end

  hsl_resp #(.IW(ID_W)) u_resp (
    .clk(clk), .rst_n(rst_n), .fire(req_valid),
    .id_d(rsp_id_d), .prev_d(rsp_prev_d), .fail_d(take_fail),
    .done_q(rsp_done), .id_q(rsp_id), .prev_q(rsp_prev), .fail_q(rsp_fail)
  );

  AST_DONE_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_done); // R2
  AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_done); // R2
  AST_FAIL_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fail |-> ($past(used_q) == '1 && rsp_id == '0)); // R5
  AST_ECHO_ID: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !is_take) |=> (rsp_id == $past(req_id) && !rsp_fail)); // R10
  always_comb begin
    if (!rst_n) AST_RESET_IDLE: assert (!rsp_done); // R1
  end
endmodule

// File: tb/hub_lock_mgr_tb.sv
module hub_lock_mgr_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [1:0] req_op = 2'b00;
  logic [2:0] req_id = 3'd0;
  logic       rsp_done, rsp_prev, rsp_fail;
  logic [2:0] rsp_id;

  int checks = 0;
  int fails  = 0;

  int m_used[NL];
  int m_state[NL];
  int e_done, e_id, e_prev, e_fail;
  string tag;

  always #(CLK_PERIOD/2) clk = ~clk;

  hub_lock_mgr u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_id(req_id), .rsp_done(rsp_done), .rsp_id(rsp_id),
    .rsp_prev(rsp_prev), .rsp_fail(rsp_fail)
  );

  task automatic check(input string r, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", r, what, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // Reference model: evaluates the request seen at each rising edge.
  always begin
    @(posedge clk);
    if (!rst_n) begin
      for (int i = 0; i < NL; i++) begin m_used[i] = 0; m_state[i] = 0; end
      e_done = 0; e_id = 0; e_prev = 0; e_fail = 0; tag = "R1";
    end else if (!req_valid) begin
      e_done = 0; e_id = 0; e_prev = 0; e_fail = 0; tag = "R2";
    end else begin
      e_done = 1; e_fail = 0; e_prev = 0; e_id = int'(req_id);
      case (req_op)
        2'b00: begin
          int pick;
          pick = -1;
          for (int i = NL - 1; i >= 0; i--) if (m_used[i] == 0) pick = i;
          if (pick < 0) begin
            e_fail = 1; e_id = 0; tag = "R5";
          end else begin
            e_id = pick; m_used[pick] = 1; m_state[pick] = 0; tag = "R3";
          end
        end
        2'b01: begin
          e_prev = m_state[req_id]; m_used[req_id] = 0; tag = "R8";
        end
        2'b10: begin
          tag = (m_used[req_id] == 0) ? "R9" : "R6";
          e_prev = m_state[req_id]; m_state[req_id] = 1;
        end
        default: begin
          tag = (m_used[req_id] == 0) ? "R9" : "R7";
          e_prev = m_state[req_id]; m_state[req_id] = 0;
        end
      endcase
    end
    #1;
    check((tag == "R1") ? "R1" : "R2", "rsp_done", int'(rsp_done), e_done);
    if (e_done == 1) begin
      check((tag == "R3" || tag == "R5") ? tag : "R10", "rsp_id", int'(rsp_id), e_id);
      check(tag, "rsp_prev", int'(rsp_prev), e_prev);
      check((tag == "R3" || tag == "R5") ? tag : "R10", "rsp_fail", int'(rsp_fail), e_fail);
    end
  end

  task automatic req(input logic [1:0] op, input int id);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_id = 3'(id);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(2);
    // R1 / R9: state starts at 0, set on a free lock reports 0
    req(2'b10, 5); req(2'b11, 5); req(2'b10, 5); idle(1);
    // R3: eight takes give 0..7; R4: lock 5 is cleared by its take
    for (int i = 0; i < NL; i++) req(2'b00, 7);
    req(2'b00, 2);                 // R5: pool empty
    req(2'b10, 5); req(2'b10, 5);  // R4 then R6
    req(2'b10, 1); idle(1);
    req(2'b00, 0);                 // R5 again, state of 1 and 5 untouched
    req(2'b11, 1); req(2'b11, 1);  // R7
    req(2'b01, 6); req(2'b01, 3);  // R8: out of order
    req(2'b00, 0); req(2'b00, 0);  // R3: gets 3, then 6
    req(2'b00, 0);                 // R5
    req(2'b01, 5); req(2'b00, 0); req(2'b10, 5); // R8 then R4
    idle(2);
    for (int k = 0; k < 600; k++) begin
      if (($urandom % 5) == 0) idle(1);
      else req(2'($urandom % 4), int'($urandom % NL));
    end
    idle(3);
    summary();
    $finish;
  end
endmodule